// File: doc/BRIEF.md
# CAN Transmit Command Sequencer

This block sits between a CAN controller's command register and its bit-level protocol engine. Every write to the command register is decoded in the cycle it arrives. The block then requests transmission from the engine and tracks the frame until it ends. A plain request is repeated automatically after each engine error. A single-shot request is given up after its first failure.

The block holds the transmit buffer lock and the transmit-complete status. It also makes the two receive-side side effects of a command write: a one-cycle pulse that releases a receive buffer, and the clearing of the sticky data-overrun flag.

The engine raises `eng_start_i` when the pending frame goes onto the bus. It then reports the end of that frame with either `eng_ok_i` or `eng_err_i`.

Top module: `can_tx_cmd_seq`

## Requirements
- R1: Command bits: bit 0 requests transmit, bit 1 aborts, bit 2 releases the receive buffer, bit 3 clears the overrun flag, bit 4 requests self-reception transmit. A write with bit 0 or bit 4 while the buffer is free makes, one cycle later, `tx_req_o`=1, `tx_buf_free_o`=0 and `tx_done_o`=0.
- R2: A write with bit 1 together with bit 0 or bit 4 is a single-shot request, not an abort. It sets `no_retry_o`=1. A request without bit 1 sets `no_retry_o`=0.
- R3: A request with bit 4 set makes `self_rx_o`=1. A request with bit 0 only makes it 0.
- R4: An engine error on a frame that allows retry returns the block to requesting (`tx_req_o`=1, `tx_busy_o`=0) in the next cycle.
- R5: An engine error on a single-shot frame frees the buffer and leaves `tx_done_o`=0.
- R6: Engine success frees the buffer and sets `tx_done_o`=1 in the next cycle.
- R7: An abort (bit 1 without bit 0 or bit 4) while a frame is pending and not started frees the buffer and sets `tx_done_o`=1 in the next cycle.
- R8: An abort while a frame is on the bus does not cut it off. An abort in the same cycle as `eng_start_i` counts as being on the bus. The frame is then not retried, and its end frees the buffer with `tx_done_o`=1.
- R9: The buffer stays locked from acceptance until the frame ends. Transmit writes while it is locked are ignored. `eng_start_i` while nothing is pending has no effect.
- R10: Bit 2 makes `rx_release_o` a single-cycle pulse in the cycle after the write.
- R11: `ovr_set_i` sets `ovr_flag_o` in the next cycle. Bit 3 clears it and pulses `ovr_clear_o`. When both occur in the same cycle, the set wins.
- R12: An abort while the buffer is free changes nothing, including a `tx_done_o` of 0.
- R13: In reset: `tx_buf_free_o`=1 and `tx_done_o`=1, and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 5 | Command write data |
| eng_start_i | input | 1 | Engine began the pending frame |
| eng_ok_i | input | 1 | Engine finished the frame successfully |
| eng_err_i | input | 1 | Engine finished the frame with an error |
| ovr_set_i | input | 1 | Receive side detected a data overrun |
| tx_req_o | output | 1 | Transmit request to the engine |
| tx_busy_o | output | 1 | Frame currently on the bus |
| tx_buf_free_o | output | 1 | Transmit buffer unlocked |
| tx_done_o | output | 1 | Transmit-complete status |
| self_rx_o | output | 1 | Current frame is also received locally |
| no_retry_o | output | 1 | Current frame is single-shot |
| rx_release_o | output | 1 | Receive buffer release pulse |
| ovr_clear_o | output | 1 | Overrun clear pulse |
| ovr_flag_o | output | 1 | Sticky data-overrun flag |

## Verification
Two events can land in the same cycle and are driven together on purpose. The first pair is an abort write and the engine's start strobe. The bench drives both on one edge and expects the frame to stay on the bus; it then reports an error and expects a freed buffer with completion set and no retry. The second pair is an overrun set and an overrun clear written together. The flag must stay at 1 while the clear pulse still appears.

// File: rtl/can_cmd_pkg.sv
package can_cmd_pkg;
  localparam int unsigned CMD_W     = 5;
  localparam int unsigned BIT_XMIT  = 0;
  localparam int unsigned BIT_ABORT = 1;
  localparam int unsigned BIT_RXREL = 2;
  localparam int unsigned BIT_OVCLR = 3;
  localparam int unsigned BIT_SELF  = 4;

  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_PEND   = 2'd1,
    TX_ACTIVE = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic xmit;
    logic self_rx;
    logic single;
    logic abort;
    logic rx_rel;
    logic ov_clr;
  } cmd_dec_t;
endpackage

// File: rtl/can_cmd_decode.sv
module can_cmd_decode
  import can_cmd_pkg::*;
(
  input  logic             we_i,
  input  logic [CMD_W-1:0] wdata_i,
  output cmd_dec_t         dec_o
);
  logic any_tx;
  assign any_tx = wdata_i[BIT_XMIT] | wdata_i[BIT_SELF];

  always_comb begin
    dec_o         = '0;
    dec_o.xmit    = we_i & any_tx;
    dec_o.self_rx = we_i & wdata_i[BIT_SELF];
    // abort bit alongside a transmit bit selects single-shot
    dec_o.single  = we_i & any_tx & wdata_i[BIT_ABORT];
    dec_o.abort   = we_i & ~any_tx & wdata_i[BIT_ABORT];
    dec_o.rx_rel  = we_i & wdata_i[BIT_RXREL];
    dec_o.ov_clr  = we_i & wdata_i[BIT_OVCLR];
  end
endmodule

// File: rtl/can_tx_fsm.sv
module can_tx_fsm
  import can_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic xmit_i,
  input  logic self_i,
  input  logic single_i,
  input  logic abort_i,
  input  logic eng_start_i,
  input  logic eng_ok_i,
  input  logic eng_err_i,
  output logic req_o,
  output logic busy_o,
  output logic free_o,
  output logic done_o,
  output logic self_o,
  output logic no_retry_o
);
  tx_state_e state_q;
  logic      abort_q;
  logic      abort_now;

  assign abort_now = abort_q | abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= TX_IDLE;
      abort_q    <= 1'b0;
      done_o     <= 1'b1;
      self_o     <= 1'b0;
      no_retry_o <= 1'b0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (xmit_i) begin
          state_q    <= TX_PEND;
          done_o     <= 1'b0;
          self_o     <= self_i;
          no_retry_o <= single_i;
          abort_q    <= 1'b0;
        end
        TX_PEND: begin
          if (eng_start_i) begin
            // frame already on the bus: abort only suppresses retry
            state_q <= TX_ACTIVE;
            abort_q <= abort_i;
          end else if (abort_i) begin
            state_q <= TX_IDLE;
            done_o  <= 1'b1;
          end
        end
        TX_ACTIVE: begin
          if (eng_ok_i) begin
            state_q <= TX_IDLE;
            done_o  <= 1'b1;
          end else if (eng_err_i) begin
            if (no_retry_o || abort_now) begin
              state_q <= TX_IDLE;
              done_o  <= abort_now;
            end else begin
              state_q <= TX_PEND;
            end
          end else if (abort_i) begin
            abort_q <= 1'b1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

  assign req_o  = (state_q == TX_PEND);
  assign busy_o = (state_q == TX_ACTIVE);
  assign free_o = (state_q == TX_IDLE);
endmodule

// File: rtl/can_aux_status.sv
module can_aux_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_rel_i,
  input  logic ov_clr_i,
  input  logic ovr_set_i,
  output logic rx_release_o,
  output logic ovr_clear_o,
  output logic ovr_flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_release_o <= 1'b0;
      ovr_clear_o  <= 1'b0;
      ovr_flag_o   <= 1'b0;
    end else begin
      rx_release_o <= rx_rel_i;
      ovr_clear_o  <= ov_clr_i;
      // a new overrun outranks a clear in the same cycle
      if (ovr_set_i)     ovr_flag_o <= 1'b1;
      else if (ov_clr_i) ovr_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/can_tx_cmd_seq.sv
module can_tx_cmd_seq
  import can_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [CMD_W-1:0] cmd_wdata_i,
  input  logic             eng_start_i,
  input  logic             eng_ok_i,
  input  logic             eng_err_i,
  input  logic             ovr_set_i,
  output logic             tx_req_o,
  output logic             tx_busy_o,
  output logic             tx_buf_free_o,
  output logic             tx_done_o,
  output logic             self_rx_o,
  output logic             no_retry_o,
  output logic             rx_release_o,
  output logic             ovr_clear_o,
  output logic             ovr_flag_o
);
  cmd_dec_t dec;

  can_cmd_decode u_dec (
    .we_i    (cmd_we_i),
    .wdata_i (cmd_wdata_i),
    .dec_o   (dec)
  );

  can_tx_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .xmit_i      (dec.xmit),
    .self_i      (dec.self_rx),
    .single_i    (dec.single),
    .abort_i     (dec.abort),
    .eng_start_i (eng_start_i),
    .eng_ok_i    (eng_ok_i),
    .eng_err_i   (eng_err_i),
    .req_o       (tx_req_o),
    .busy_o      (tx_busy_o),
    .free_o      (tx_buf_free_o),
    .done_o      (tx_done_o),
    .self_o      (self_rx_o),
    .no_retry_o  (no_retry_o)
  );

  can_aux_status u_aux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_rel_i     (dec.rx_rel),
    .ov_clr_i     (dec.ov_clr),
    .ovr_set_i    (ovr_set_i),
    .rx_release_o (rx_release_o),
    .ovr_clear_o  (ovr_clear_o),
    .ovr_flag_o   (ovr_flag_o)
  );
endmodule

// File: rtl/can_tx_cmd_seq_chk.sv
module can_tx_cmd_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_we_i,
  input logic [4:0] cmd_wdata_i,
  input logic       eng_start_i,
  input logic       eng_ok_i,
  input logic       ovr_set_i,
  input logic       tx_req_o,
  input logic       tx_busy_o,
  input logic       tx_buf_free_o,
  input logic       tx_done_o,
  input logic       self_rx_o,
  input logic       rx_release_o,
  input logic       ovr_flag_o
);
  logic wr_tx, wr_abort;
  assign wr_tx    = cmd_we_i & (cmd_wdata_i[0] | cmd_wdata_i[4]);
  assign wr_abort = cmd_we_i & cmd_wdata_i[1] & ~cmd_wdata_i[0] & ~cmd_wdata_i[4];

  assert_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_buf_free_o && wr_tx |=> tx_req_o && !tx_done_o && !tx_buf_free_o);

  assert_self_rx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_buf_free_o && cmd_we_i && cmd_wdata_i[4] |=> self_rx_o);

  assert_success_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_o && eng_ok_i |=> tx_buf_free_o && tx_done_o);

  assert_abort_pend_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o && !eng_start_i && wr_abort |=> tx_buf_free_o && tx_done_o);

  assert_rx_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_wdata_i[2] |=> rx_release_o);

  assert_ovr_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_set_i |=> ovr_flag_o);
endmodule

bind can_tx_cmd_seq can_tx_cmd_seq_chk chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_we_i      (cmd_we_i),
  .cmd_wdata_i   (cmd_wdata_i),
  .eng_start_i   (eng_start_i),
  .eng_ok_i      (eng_ok_i),
  .ovr_set_i     (ovr_set_i),
  .tx_req_o      (tx_req_o),
  .tx_busy_o     (tx_busy_o),
  .tx_buf_free_o (tx_buf_free_o),
  .tx_done_o     (tx_done_o),
  .self_rx_o     (self_rx_o),
  .rx_release_o  (rx_release_o),
  .ovr_flag_o    (ovr_flag_o)
);

// File: tb/can_tx_cmd_seq_tb_top.sv
module can_tx_cmd_seq_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_we_i = 1'b0;
  logic [4:0] cmd_wdata_i = '0;
  logic       eng_start_i = 1'b0, eng_ok_i = 1'b0, eng_err_i = 1'b0, ovr_set_i = 1'b0;
  logic tx_req_o, tx_busy_o, tx_buf_free_o, tx_done_o, self_rx_o, no_retry_o;
  logic rx_release_o, ovr_clear_o, ovr_flag_o;
  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  can_tx_cmd_seq dut_i (.*);

  // observed bits: req free done busy self noretry rel ovclr ovr
  logic [8:0] obs;
  assign obs = {tx_req_o, tx_buf_free_o, tx_done_o, tx_busy_o, self_rx_o,
                no_retry_o, rx_release_o, ovr_clear_o, ovr_flag_o};

  // vector: {we, cmd[4:0], start, ok, err, ovr_set, expected[8:0]}
  localparam int NV = 26;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1,5'h01,4'b0000,9'b100000000},  // R1 accept
    {1'b0,5'h00,4'b1000,9'b000100000},  // R9 on bus
    {1'b0,5'h00,4'b0010,9'b100000000},  // R4 retry
    {1'b0,5'h00,4'b1000,9'b000100000},
    {1'b0,5'h00,4'b0100,9'b011000000},  // R6 success
    {1'b1,5'h03,4'b0000,9'b100001000},  // R2 single-shot
    {1'b0,5'h00,4'b1000,9'b000101000},
    {1'b0,5'h00,4'b0010,9'b010001000},  // R5 give up
    {1'b1,5'h12,4'b0000,9'b100011000},  // R3 self single
    {1'b0,5'h00,4'b1000,9'b000111000},
    {1'b0,5'h00,4'b0100,9'b011011000},  // R6
    {1'b1,5'h10,4'b0000,9'b100010000},  // R3 self retry
    {1'b1,5'h02,4'b0000,9'b011010000},  // R7 abort pending
    {1'b1,5'h01,4'b0000,9'b100000000},  // R1
    {1'b1,5'h11,4'b0000,9'b100000000},  // R9 locked write ignored
    {1'b0,5'h00,4'b1000,9'b000100000},
    {1'b1,5'h02,4'b0000,9'b000100000},  // R8 abort on bus
    {1'b0,5'h00,4'b0010,9'b011000000},  // R8 no retry, done
    {1'b1,5'h04,4'b0000,9'b011000100},  // R10 pulse
    {1'b0,5'h00,4'b0000,9'b011000000},  // R10 single cycle
    {1'b0,5'h00,4'b0001,9'b011000001},  // R11 set
    {1'b1,5'h08,4'b0000,9'b011000010},  // R11 clear
    {1'b1,5'h08,4'b0001,9'b011000011},  // R11 set wins
    {1'b1,5'h08,4'b0000,9'b011000010},
    {1'b1,5'h02,4'b0000,9'b011000000},  // R12 idle abort
    {1'b1,5'h0D,4'b0000,9'b100000110}   // R1 R10 combined
  };
  localparam int REQ [NV] = '{1,9,4,9,6,2,9,5,3,9,6,3,7,1,9,9,8,8,10,10,11,11,11,11,12,1};

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic step(input logic we, input logic [4:0] d, input logic [3:0] eng);
    @(negedge clk_i);
    cmd_we_i = we; cmd_wdata_i = d;
    {eng_start_i, eng_ok_i, eng_err_i, ovr_set_i} = eng;
    @(posedge clk_i);
    #1;
    cmd_we_i = 1'b0; cmd_wdata_i = '0;
    {eng_start_i, eng_ok_i, eng_err_i, ovr_set_i} = 4'b0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    #12;
    chk("R13 reset state", obs, 9'b011000000);
    do_reset();
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][18], VEC[i][17:13], VEC[i][12:9]);
      chk($sformatf("R%0d vec%0d", REQ[i], i), obs, VEC[i][8:0]);
    end

    // R8: abort written in the same cycle as engine start
    do_reset();
    step(1'b1, 5'h01, 4'b0000);
    step(1'b1, 5'h02, 4'b1000);
    chk("R8 abort with start keeps frame", obs, 9'b000100000);
    step(1'b0, 5'h00, 4'b0010);
    chk("R8 error after abort ends frame", obs, 9'b011000000);

    // R12: idle abort leaves a failed status at 0
    step(1'b1, 5'h03, 4'b0000);
    step(1'b0, 5'h00, 4'b1000);
    step(1'b0, 5'h00, 4'b0010);
    chk("R5 single-shot failure", obs, 9'b010001000);
    step(1'b1, 5'h02, 4'b0000);
    chk("R12 idle abort ignored", obs, 9'b010001000);

    // R9: start strobe with nothing pending
    step(1'b0, 5'h00, 4'b1000);
    chk("R9 stray start ignored", obs, 9'b010001000);

    // R13: asynchronous reset mid-frame
    step(1'b1, 5'h13, 4'b0000);
    #2 rst_ni = 1'b0;
    #1 chk("R13 async reset", obs, 9'b011000000);
    do_reset();
    report();
  end
endmodule